// File: doc/BRIEF.md
# Multicycle Processor Sequencer

This block is the controller for a processor datapath in which one instruction takes several clock cycles, and in which a single memory and a single ALU serve every step. A Moore state machine steps through fetch, decode and then one of several execution paths chosen by the opcode held in the instruction register. In every state it drives the datapath's multiplexer selects, its write enables and the ALU operation code. Because the outputs depend only on the current state, they are stable for the whole cycle.

The ALU is shared across cycles. During fetch it adds four to the program counter. During decode it adds the shifted offset to the program counter, so a possible branch target is ready early. In later cycles it computes a memory address, an arithmetic result or a comparison. The block also merges the unconditional and conditional program-counter write enables with the ALU zero flag into a single load strobe for the program counter.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: An active-low asynchronous reset, applied in any state, puts the machine in the fetch state, and it stays there until reset is released.
- R2: In fetch, mem_read=1, ir_load=1, pc_write=1, alu_src_a=0, alu_src_b=2'b01 (constant 4), alu_op=2'b00 (add) and pc_source=2'b00, with every other control at 0. The next state is always decode.
- R3: In decode, alu_src_a=0, alu_src_b=2'b11 (shifted immediate) and alu_op=2'b00, with all write enables at 0. The next state depends on the opcode.
- R4: A load (opcode 6'd35) runs through five cycles. Address cycle: alu_src_a=1, alu_src_b=2'b10. Read cycle: mem_read=1, addr_sel=1. Write-back cycle: reg_write=1, mem_to_reg=1, reg_dst=0.
- R5: A store (opcode 6'd43) runs through four cycles: the same address cycle as a load, then mem_write=1 with addr_sel=1. mem_read and mem_write are never both 1.
- R6: A register-register operation (opcode 6'd0) runs through four cycles. Compute cycle: alu_src_a=1, alu_src_b=2'b00, alu_op=2'b10. Write-back cycle: reg_dst=1, reg_write=1, mem_to_reg=0.
- R7: A branch-if-equal (opcode 6'd4) runs through three cycles. Its last cycle has alu_src_a=1, alu_src_b=2'b00, alu_op=2'b01, pc_write_cond=1 and pc_source=2'b01, and pc_load equals alu_zero in that cycle.
- R8: A jump (opcode 6'd2) runs through three cycles. Its last cycle has pc_write=1 and pc_source=2'b10.
- R9: Any other opcode returns to fetch directly after decode. No write enable is raised in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | OPW | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| reg_dst | output | 1 | Destination register from rd field (1) or rt field (0) |
| reg_write | output | 1 | Register file write enable |
| alu_src_a | output | 1 | ALU operand A: register A (1) or PC (0) |
| mem_read | output | 1 | Memory read enable |
| mem_write | output | 1 | Memory write enable |
| mem_to_reg | output | 1 | Register write data from MDR (1) or ALUOut (0) |
| addr_sel | output | 1 | Memory address from ALUOut (1) or PC (0) |
| ir_load | output | 1 | Instruction register load enable |
| pc_write | output | 1 | Unconditional PC write |
| pc_write_cond | output | 1 | PC write qualified by zero flag |
| alu_op | output | 2 | 00 add, 01 subtract, 10 function field |
| alu_src_b | output | 2 | 00 B, 01 constant 4, 10 immediate, 11 immediate shifted by 2 |
| pc_source | output | 2 | 00 ALU result, 01 ALUOut, 10 jump target |
| pc_load | output | 1 | Effective PC load strobe |

## Verification
The bench builds the block with its default parameters: a 6-bit opcode and the default code for each instruction class. With these values every path is reachable from the real encodings, and 6'h3F serves as an opcode that matches no class, which is needed to exercise R9. The branch path is run once with the zero flag set and once with it clear, so both values of pc_load are seen. Reset is also asserted in the middle of a register-register instruction, to show that the machine goes back to fetch from a state other than fetch.

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm #(
  parameter int OPW       = 6,
  parameter logic [OPW-1:0] OP_RTYPE = 6'd0,
  parameter logic [OPW-1:0] OP_LOAD  = 6'd35,
  parameter logic [OPW-1:0] OP_STORE = 6'd43,
  parameter logic [OPW-1:0] OP_BEQ   = 6'd4,
  parameter logic [OPW-1:0] OP_JUMP  = 6'd2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] opcode,
  input  logic           alu_zero,
  output logic           reg_dst,
  output logic           reg_write,
  output logic           alu_src_a,
  output logic           mem_read,
  output logic           mem_write,
  output logic           mem_to_reg,
  output logic           addr_sel,
  output logic           ir_load,
  output logic           pc_write,
  output logic           pc_write_cond,
  output logic [1:0]     alu_op,
  output logic [1:0]     alu_src_b,
  output logic [1:0]     pc_source,
  output logic           pc_load
);

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_MADDR, S_MRD, S_LDWB,
    S_MWR, S_EXEC, S_RWB, S_BRANCH, S_JUMP
  } step_t;

  step_t state, state_nx;

  wire is_mem = (opcode == OP_LOAD) || (opcode == OP_STORE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= S_FETCH;
    else        state <= state_nx;

  always_comb begin
    state_nx = S_FETCH;
    case (state)
      S_FETCH:  state_nx = S_DECODE;
      S_DECODE: begin
        if (is_mem)                 state_nx = S_MADDR;
        else if (opcode == OP_RTYPE) state_nx = S_EXEC;
        else if (opcode == OP_BEQ)   state_nx = S_BRANCH;
        else if (opcode == OP_JUMP)  state_nx = S_JUMP;
        else                         state_nx = S_FETCH;
      end
      S_MADDR:  state_nx = (opcode == OP_STORE) ? S_MWR : S_MRD;
      S_MRD:    state_nx = S_LDWB;
      S_EXEC:   state_nx = S_RWB;
      default:  state_nx = S_FETCH;
    endcase
  end

  always_comb begin
    reg_dst = 1'b0;  reg_write = 1'b0;  alu_src_a = 1'b0;
    mem_read = 1'b0; mem_write = 1'b0;  mem_to_reg = 1'b0;
    addr_sel = 1'b0; ir_load = 1'b0;    pc_write = 1'b0;
    pc_write_cond = 1'b0;
    alu_op = 2'b00;  alu_src_b = 2'b00; pc_source = 2'b00;
    case (state)
      S_FETCH: begin
        mem_read = 1'b1; ir_load = 1'b1; pc_write = 1'b1;
        alu_src_b = 2'b01;
      end
      S_DECODE: alu_src_b = 2'b11;
      S_MADDR: begin
        alu_src_a = 1'b1; alu_src_b = 2'b10;
      end
      S_MRD: begin
        mem_read = 1'b1; addr_sel = 1'b1;
      end
      S_LDWB: begin
        reg_write = 1'b1; mem_to_reg = 1'b1;
      end
      S_MWR: begin
        mem_write = 1'b1; addr_sel = 1'b1;
      end
      S_EXEC: begin
        alu_src_a = 1'b1; alu_op = 2'b10;
      end
      S_RWB: begin
        reg_dst = 1'b1; reg_write = 1'b1;
      end
      S_BRANCH: begin
        alu_src_a = 1'b1; alu_op = 2'b01;
        pc_write_cond = 1'b1; pc_source = 2'b01;
      end
      S_JUMP: begin
        pc_write = 1'b1; pc_source = 2'b10;
      end
      default: ;
    endcase
  end

  assign pc_load = pc_write | (pc_write_cond & alu_zero);

  // R2
  fetch_to_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |=> (state == S_DECODE));

  // R4
  read_then_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_read && addr_sel) |=> (reg_write && mem_to_reg));

  // R5
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_read && mem_write));

  // R7
  branch_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_write_cond |=> ir_load);

  // R8
  jump_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_write && !ir_load) |-> (pc_source == 2'b10));

  // R9
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_DECODE) && !is_mem && opcode != OP_RTYPE &&
     opcode != OP_BEQ && opcode != OP_JUMP) |=> ir_load);

endmodule

// File: tb/mc_ctrl_fsm_bench.sv
module mc_ctrl_fsm_bench;
  localparam int CLK_PERIOD = 10;

  localparam int ST_FETCH = 0, ST_DEC = 1, ST_MADDR = 2, ST_MRD = 3, ST_LDWB = 4,
                 ST_MWR = 5, ST_EXEC = 6, ST_RWB = 7, ST_BR = 8, ST_JMP = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] opcode = 6'd0;
  logic alu_zero = 1'b0;
  logic reg_dst, reg_write, alu_src_a, mem_read, mem_write, mem_to_reg;
  logic addr_sel, ir_load, pc_write, pc_write_cond, pc_load;
  logic [1:0] alu_op, alu_src_b, pc_source;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [16:0] q_vec[$];
  string       q_tag[$];

  mc_ctrl_fsm u_mc_ctrl_fsm (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero),
    .reg_dst(reg_dst), .reg_write(reg_write), .alu_src_a(alu_src_a),
    .mem_read(mem_read), .mem_write(mem_write), .mem_to_reg(mem_to_reg),
    .addr_sel(addr_sel), .ir_load(ir_load), .pc_write(pc_write),
    .pc_write_cond(pc_write_cond), .alu_op(alu_op), .alu_src_b(alu_src_b),
    .pc_source(pc_source), .pc_load(pc_load)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected controls per step:
  // {reg_dst,reg_write,src_a,mem_rd,mem_wr,mem_to_reg,addr_sel,ir_load,pc_wr,pc_wc,alu_op,src_b,pc_src,pc_load}
  function automatic logic [16:0] expect_ctl(int st, logic z);
    logic [15:0] v;
    case (st)
      ST_FETCH: v = {10'b0001000110, 2'b00, 2'b01, 2'b00};
      ST_DEC:   v = {10'b0000000000, 2'b00, 2'b11, 2'b00};
      ST_MADDR: v = {10'b0010000000, 2'b00, 2'b10, 2'b00};
      ST_MRD:   v = {10'b0001001000, 2'b00, 2'b00, 2'b00};
      ST_LDWB:  v = {10'b0100010000, 2'b00, 2'b00, 2'b00};
      ST_MWR:   v = {10'b0000101000, 2'b00, 2'b00, 2'b00};
      ST_EXEC:  v = {10'b0010000000, 2'b10, 2'b00, 2'b00};
      ST_RWB:   v = {10'b1100000000, 2'b00, 2'b00, 2'b00};
      ST_BR:    v = {10'b0010000001, 2'b01, 2'b00, 2'b01};
      default:  v = {10'b0000000010, 2'b00, 2'b00, 2'b10};
    endcase
    return {v, v[7] | (v[6] & z)};
  endfunction

  task automatic push_step(int st, logic z, string tag);
    alu_zero = z;
    q_vec.push_back(expect_ctl(st, z));
    q_tag.push_back(tag);
  endtask

  task automatic run_instr(logic [5:0] op, logic z, int steps[$], string tag);
    opcode = op;
    foreach (steps[i]) begin
      push_step(steps[i], z, tag);
      @(posedge clk); #1;
    end
  endtask

  always @(negedge clk) begin
    if (q_vec.size() > 0) begin
      logic [16:0] e;
      logic [16:0] a;
      string t;
      e = q_vec.pop_front();
      t = q_tag.pop_front();
      a = {reg_dst, reg_write, alu_src_a, mem_read, mem_write, mem_to_reg,
           addr_sel, ir_load, pc_write, pc_write_cond, alu_op, alu_src_b,
           pc_source, pc_load};
      n_checks++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: actual %b expected %b", t, a, e);
      end
    end
  end

  initial begin
    // R1: controls during reset are the fetch controls
    push_step(ST_FETCH, 1'b0, "R1");
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    // R6 register-register, R2/R3 on its first two cycles
    run_instr(6'd0, 1'b0, '{ST_FETCH, ST_DEC, ST_EXEC, ST_RWB}, "R6");
    // R4 load
    run_instr(6'd35, 1'b0, '{ST_FETCH, ST_DEC, ST_MADDR, ST_MRD, ST_LDWB}, "R4");
    // R5 store
    run_instr(6'd43, 1'b0, '{ST_FETCH, ST_DEC, ST_MADDR, ST_MWR}, "R5");
    // R7 branch, taken then not taken
    run_instr(6'd4, 1'b1, '{ST_FETCH, ST_DEC, ST_BR}, "R7");
    run_instr(6'd4, 1'b0, '{ST_FETCH, ST_DEC, ST_BR}, "R7");
    // R8 jump
    run_instr(6'd2, 1'b0, '{ST_FETCH, ST_DEC, ST_JMP}, "R8");
    // R9 undefined opcode
    run_instr(6'h3F, 1'b1, '{ST_FETCH, ST_DEC}, "R9");
    // R2 fetch after undefined opcode, with zero high not affecting pc_load
    run_instr(6'd0, 1'b1, '{ST_FETCH, ST_DEC}, "R2");
    // R1: reset in the compute cycle of a register-register op
    rst_n = 1'b0;
    push_step(ST_FETCH, 1'b0, "R1");
    @(posedge clk); #1;
    push_step(ST_FETCH, 1'b0, "R1");
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R3: decode after reset leads to the load path
    run_instr(6'd35, 1'b0, '{ST_DEC, ST_MADDR, ST_MRD, ST_LDWB, ST_FETCH}, "R3");
    @(negedge clk); #1;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule